// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block watches 128 general-purpose pins, organised as four banks of 32, and records rising and falling transitions in sticky per-pin status bits. Each raw pin input first passes through a two-flop synchronizer. The block then compares the synchronized level with the level from the previous cycle. A transition sets the pin's status bit only when the pin is configured as an input and the matching edge enable for that pin is set. Software clears status bits by writing ones to a bank through a small clear port. Register decode happens outside this block. The direction and enable masks come in as plain input vectors.

The status bits are folded into three registered level interrupts. Pin 0 and pin 1 each have their own interrupt line. Every other pin shares a third line. The block also raises a one-cycle wake pulse while the processor reports that it is halted, when any input pin from a fixed, hardwired set changes level.

Top module: `gpio_edge_irq_agg`

## Requirements
- R1: A pin change is seen through two synchronizer flops. A change applied before clock edge k can first show up in `status_o` after edge k+2, and no earlier.
- R2: A pin's status bit is set when its synchronized level goes from 0 to 1, the pin is an input (`pin_dir` bit 0), and its `rise_en` bit is 1.
- R3: A pin's status bit is set when its synchronized level goes from 1 to 0, the pin is an input, and its `fall_en` bit is 1.
- R4: No transition on a pin whose `pin_dir` bit is 1 (output) changes its status bit.
- R5: Status bits stay set until cleared. A cycle with `clr_we`=1 clears the bits of bank `clr_bank` (status bits `clr_bank*32 +: 32`) where `clr_mask` is 1. Zero mask bits, and all other banks, are left unchanged.
- R6: When an enabled edge and a clear hit the same status bit in the same cycle, the bit stays set.
- R7: `irq_pin0` equals status bit 0 and `irq_pin1` equals status bit 1, in every cycle.
- R8: `irq_shared` is the OR of status bits 2 to 127, in every cycle.
- R9: The wake-capable pins are given by per-bank masks: 0x8003FE1B for bank 0, 0x002001FC for bank 1, 0xEC080000 for bank 2 and 0x0012007F for bank 3. If `halted` is 1 in the cycle where a wake-capable input pin's synchronized level changes, `wake_pulse` is 1 for exactly the following cycle. Its timing matches the status update.
- R10: A level change produces no wake pulse in any of these cases: `halted` is 0, the pin is outside the wake masks, or the pin is an output.
- R11: The previous-level sample is updated every cycle, whatever the enables are. Turning on an edge enable after a pin has already settled at its new level does not set the status bit.
- R12: While `rst_n` is low, and right after it is released, `status_o`, all three interrupts and `wake_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 128 | Raw pin levels, asynchronous to clk |
| pin_dir | input | 128 | 1 = pin is an output, 0 = input |
| rise_en | input | 128 | Per-pin rising-edge enable |
| fall_en | input | 128 | Per-pin falling-edge enable |
| clr_we | input | 1 | Clear strobe for one cycle |
| clr_bank | input | 2 | Bank that the clear applies to |
| clr_mask | input | 32 | Write-one-to-clear mask for that bank |
| halted | input | 1 | Processor is halted |
| status_o | output | 128 | Sticky edge status, pin n at bit n |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt for pins 2 to 127 |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
Directed patterns drive single pins in turn. These include a rise and a fall on the dedicated pins, transitions on output pins, an enable turned on after a level has settled, and a clear that lands in the same cycle as an edge. Together they separate correct edge qualification from level sensitivity, from a missing direction gate, and from the wrong priority between clear and edge. Wake tests toggle a wake-capable pin and a non-capable pin, with halted both set and cleared, which checks the hardwired masks and the halted gating. A long random phase flips sparse pin subsets and changes direction and enables at random. During this phase, bank-addressed clears and halted also toggle at random. This exercises the shared-line fold and the bank decode of clears across all four banks.

// File: rtl/gpio_agg_pkg.sv
package gpio_agg_pkg;

    // Default geometry of the pin array
    localparam int unsigned DEF_NUM_BANKS = 4;
    localparam int unsigned DEF_BANK_W    = 32;
    localparam int unsigned DEF_NUM_PINS  = DEF_NUM_BANKS * DEF_BANK_W;

    // Pins that own a private interrupt line (pin 0 and pin 1)
    localparam int unsigned DEDICATED_IRQS = 2;

    // Hardwired wake-capable pins, bank 3 in the top word down to bank 0
    localparam logic [DEF_NUM_PINS-1:0] DEF_WAKE_MASK =
        128'h0012007F_EC080000_002001FC_8003FE1B;

endpackage

// File: rtl/gpio_agg_sync.sv
module gpio_agg_sync #(
    parameter int unsigned WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] cur;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o  = st_q.cur;
    assign prev_o = st_q.prev;

endmodule

// File: rtl/gpio_agg_bank.sv
module gpio_agg_bank #(
    parameter int unsigned       BANK_W    = 32,
    parameter logic [BANK_W-1:0] WAKE_BITS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] cur_i,
    input  logic [BANK_W-1:0] prev_i,
    input  logic [BANK_W-1:0] dir_out_i,
    input  logic [BANK_W-1:0] rise_en_i,
    input  logic [BANK_W-1:0] fall_en_i,
    input  logic [BANK_W-1:0] clr_i,
    input  logic              halted_i,
    output logic [BANK_W-1:0] status_d_o,
    output logic [BANK_W-1:0] status_q_o,
    output logic              wake_hit_o
);

    typedef struct packed {
        logic [BANK_W-1:0] status;
    } bank_t;

    bank_t bk_d, bk_q;

    logic [BANK_W-1:0] in_mask;
    logic [BANK_W-1:0] rise_hit;
    logic [BANK_W-1:0] fall_hit;
    logic [BANK_W-1:0] level_chg;

    always_comb begin
        in_mask   = ~dir_out_i;
        rise_hit  = cur_i & ~prev_i & rise_en_i & in_mask;
        fall_hit  = ~cur_i & prev_i & fall_en_i & in_mask;
        level_chg = (cur_i ^ prev_i) & in_mask;

        bk_d        = bk_q;
        // Clear first, then edges, so a same-cycle edge survives the clear
        bk_d.status = (bk_q.status & ~clr_i) | rise_hit | fall_hit;

        wake_hit_o  = halted_i & (|(level_chg & WAKE_BITS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign status_d_o = bk_d.status;
    assign status_q_o = bk_q.status;

endmodule

// File: rtl/gpio_agg_irq_fold.sv
module gpio_agg_irq_fold #(
    parameter int unsigned NUM_PINS  = 128,
    parameter int unsigned DEDICATED = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  status_next_i,
    input  logic                 wake_any_i,
    output logic [DEDICATED-1:0] irq_ded_o,
    output logic                 irq_shared_o,
    output logic                 wake_o
);

    typedef struct packed {
        logic [DEDICATED-1:0] ded;
        logic                 shared;
        logic                 wake;
    } fold_t;

    fold_t fd_d, fd_q;

    always_comb begin
        fd_d        = fd_q;
        fd_d.ded    = status_next_i[DEDICATED-1:0];
        fd_d.shared = |status_next_i[NUM_PINS-1:DEDICATED];
        fd_d.wake   = wake_any_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fd_q <= '0;
        end else begin
            fd_q <= fd_d;
        end
    end

    assign irq_ded_o    = fd_q.ded;
    assign irq_shared_o = fd_q.shared;
    assign wake_o       = fd_q.wake;

endmodule

// File: rtl/gpio_edge_irq_agg.sv
module gpio_edge_irq_agg
    import gpio_agg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = DEF_NUM_BANKS,
    parameter int unsigned BANK_W    = DEF_BANK_W,
    parameter logic [NUM_BANKS*BANK_W-1:0] WAKE_MASK = DEF_WAKE_MASK
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0]                 pin_in,
    input  logic [NUM_BANKS*BANK_W-1:0]                 pin_dir,
    input  logic [NUM_BANKS*BANK_W-1:0]                 rise_en,
    input  logic [NUM_BANKS*BANK_W-1:0]                 fall_en,
    input  logic                                        clr_we,
    input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] clr_bank,
    input  logic [BANK_W-1:0]                           clr_mask,
    input  logic                                        halted,
    output logic [NUM_BANKS*BANK_W-1:0]                 status_o,
    output logic                                        irq_pin0,
    output logic                                        irq_pin1,
    output logic                                        irq_shared
    ,
    output logic                                        wake_pulse
);

    localparam int unsigned NUM_PINS   = NUM_BANKS * BANK_W;
    localparam int unsigned BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [NUM_PINS-1:0]       cur_lvl;
    logic [NUM_PINS-1:0]       prev_lvl;
    logic [NUM_PINS-1:0]       status_next;
    logic [NUM_PINS-1:0]       status_now;
    logic [NUM_BANKS-1:0]      wake_hits;
    logic [DEDICATED_IRQS-1:0] irq_ded;

    gpio_agg_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .cur_o  (cur_lvl),
        .prev_o (prev_lvl)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] clr_vec;

        assign clr_vec = (clr_we && (clr_bank == BANK_SEL_W'(b))) ? clr_mask : '0;

        gpio_agg_bank #(
            .BANK_W    (BANK_W),
            .WAKE_BITS (WAKE_MASK[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .cur_i      (cur_lvl[b*BANK_W +: BANK_W]),
            .prev_i     (prev_lvl[b*BANK_W +: BANK_W]),
            .dir_out_i  (pin_dir[b*BANK_W +: BANK_W]),
            .rise_en_i  (rise_en[b*BANK_W +: BANK_W]),
            .fall_en_i  (fall_en[b*BANK_W +: BANK_W]),
            .clr_i      (clr_vec),
            .halted_i   (halted),
            .status_d_o (status_next[b*BANK_W +: BANK_W]),
            .status_q_o (status_now[b*BANK_W +: BANK_W]),
            .wake_hit_o (wake_hits[b])
        );
    end

    gpio_agg_irq_fold #(
        .NUM_PINS  (NUM_PINS),
        .DEDICATED (DEDICATED_IRQS)
    ) u_fold (
        .clk           (clk),
        .rst_n         (rst_n),
        .status_next_i (status_next),
        .wake_any_i    (|wake_hits),
        .irq_ded_o     (irq_ded),
        .irq_shared_o  (irq_shared),
        .wake_o        (wake_pulse)
    );

    assign status_o = status_now;
    assign irq_pin0 = irq_ded[0];
    assign irq_pin1 = irq_ded[1];

endmodule

// File: rtl/gpio_edge_irq_agg_chk.sv
module gpio_edge_irq_agg_chk #(
    parameter int unsigned NUM_PINS = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr_we,
    input logic                halted,
    input logic [NUM_PINS-1:0] status_o,
    input logic                irq_pin0,
    input logic                irq_pin1,
    input logic                irq_shared,
    input logic                wake_pulse
);

    // R7: dedicated lines track their status bits
    p_irq0_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin0 == status_o[0]);

    p_irq1_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin1 == status_o[1]);

    // R8: shared line folds the remaining bits
    p_shared_fold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared == (|status_o[NUM_PINS-1:2]));

    // R5: without a clear no status bit can drop
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R10: a wake pulse needs halted in the detecting cycle
    p_wake_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(halted));

endmodule

bind gpio_edge_irq_agg gpio_edge_irq_agg_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_we     (clr_we),
    .halted     (halted),
    .status_o   (status_o),
    .irq_pin0   (irq_pin0),
    .irq_pin1   (irq_pin1),
    .irq_shared (irq_shared),
    .wake_pulse (wake_pulse)
);

// File: tb/gpio_edge_irq_agg_tb.sv
module gpio_edge_irq_agg_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] WAKE = 128'h0012007F_EC080000_002001FC_8003FE1B;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] pin = '0, dir = '0, re = '0, fe = '0;
    logic         clr_we = 1'b0;
    logic [1:0]   clr_bank = '0;
    logic [31:0]  clr_mask = '0;
    logic         halted = 1'b0;
    logic [127:0] status_o;
    logic         irq_pin0, irq_pin1, irq_shared, wake_pulse;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;
    string tag = "R12";

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_irq_agg u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin),
        .pin_dir    (dir),
        .rise_en    (re),
        .fall_en    (fe),
        .clr_we     (clr_we),
        .clr_bank   (clr_bank),
        .clr_mask   (clr_mask),
        .halted     (halted),
        .status_o   (status_o),
        .irq_pin0   (irq_pin0),
        .irq_pin1   (irq_pin1),
        .irq_shared (irq_shared),
        .wake_pulse (wake_pulse)
    );

    // Reference model built from the requirements
    logic [127:0] m_s1, m_s2, m_prev, m_stat;
    logic         m_wake;

    function automatic logic [127:0] f_edges(input logic [127:0] c, p, d, r, f);
        return ((c & ~p & r) | (~c & p & f)) & ~d;
    endfunction

    function automatic logic [127:0] f_clear(input logic we, input logic [1:0] bank,
                                             input logic [31:0] mask);
        logic [127:0] v;
        v = '0;
        if (we) v[bank*32 +: 32] = mask;
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0; m_wake <= 1'b0;
        end else begin
            m_s1   <= pin;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_stat <= (m_stat & ~f_clear(clr_we, clr_bank, clr_mask))
                      | f_edges(m_s2, m_prev, dir, re, fe);
            m_wake <= halted & (|((m_s2 ^ m_prev) & ~dir & WAKE));
        end
    end

    task automatic check1(input string req, input logic [127:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            check1(tag, status_o, m_stat);
            check1("R7", {127'b0, irq_pin0}, {127'b0, m_stat[0]});
            check1("R7", {127'b0, irq_pin1}, {127'b0, m_stat[1]});
            check1("R8", {127'b0, irq_shared}, {127'b0, |m_stat[127:2]});
            check1("R9", {127'b0, wake_pulse}, {127'b0, m_wake});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear(input logic [1:0] bank, input logic [31:0] mask);
        clr_we = 1'b1; clr_bank = bank; clr_mask = mask;
        step(1);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    int wcount;

    initial begin
        void'($urandom(32'd20240611));
        chk_en = 1'b1;
        // R12: reset state
        tag = "R12";
        step(3);
        check1("R12", status_o, '0);
        rst_n = 1'b1;
        step(3);
        check1("R12", {124'b0, irq_pin0, irq_pin1, irq_shared, wake_pulse}, '0);

        // R2 with R1 latency: rise on pins 0, 1 and 37
        tag = "R2";
        re = '1;
        pin[0] = 1'b1; pin[1] = 1'b1; pin[37] = 1'b1;
        step(2);
        check1("R1", {127'b0, status_o[0]}, 128'd0);
        step(1);
        check1("R1", {127'b0, status_o[0]}, 128'd1);
        step(3);
        check1("R2", status_o, (128'b1 << 37) | 128'h3);

        // R3: fall on pin 1 with falling enable
        tag = "R3";
        fe = '1; pin[1] = 1'b0;
        step(5);
        // R5: clears and no-effect writes
        tag = "R5";
        clear(2'd0, 32'h1);
        check1("R5", {127'b0, status_o[0]}, 128'd0);
        clear(2'd0, 32'h0);
        clear(2'd2, 32'h20);
        check1("R5", {127'b0, status_o[37]}, 128'd1);
        clear(2'd1, 32'h20);
        check1("R5", {127'b0, status_o[37]}, 128'd0);
        clear(2'd0, 32'hFFFF_FFFF);
        step(2);

        // R4: output pins never latch edges
        tag = "R4";
        dir = '1;
        pin = ~pin;
        step(4);
        pin = ~pin;
        step(4);
        check1("R4", status_o, '0);
        dir = '0;
        step(4);

        // R11: enabling after the level settled
        tag = "R11";
        re = '0; fe = '0;
        pin[40] = ~pin[40];
        step(4);
        re = '1; fe = '1;
        step(4);
        check1("R11", {127'b0, status_o[40]}, 128'd0);

        // R6: edge and clear in the same cycle
        tag = "R6";
        pin[0] = 1'b0;
        step(4);
        pin[0] = 1'b1;
        step(4);
        pin[0] = 1'b0;
        step(2);
        clear(2'd0, 32'h1);
        step(1);
        check1("R6", {127'b0, status_o[0]}, 128'd1);
        clear(2'd0, 32'hFFFF_FFFF);

        // R9: wake from a capable pin while halted
        tag = "R9";
        halted = 1'b1;
        pin[0] = ~pin[0];
        wcount = 0;
        for (int i = 0; i < 6; i++) begin step(1); wcount += int'(wake_pulse); end
        check1("R9", 128'(wcount), 128'd1);
        // R10: pin 2 is not wake-capable
        tag = "R10";
        pin[2] = ~pin[2];
        wcount = 0;
        for (int i = 0; i < 6; i++) begin step(1); wcount += int'(wake_pulse); end
        check1("R10", 128'(wcount), 128'd0);
        // R10: not halted
        halted = 1'b0;
        pin[0] = ~pin[0];
        wcount = 0;
        for (int i = 0; i < 6; i++) begin step(1); wcount += int'(wake_pulse); end
        check1("R10", 128'(wcount), 128'd0);
        // R10: halted but output pin
        halted = 1'b1;
        dir[0] = 1'b1;
        pin[0] = ~pin[0];
        wcount = 0;
        for (int i = 0; i < 6; i++) begin step(1); wcount += int'(wake_pulse); end
        check1("R10", 128'(wcount), 128'd0);
        dir[0] = 1'b0;

        // R8: random mix across all banks
        tag = "R8";
        for (int i = 0; i < 3000; i++) begin
            if (i % 64 == 0) begin
                dir = {$urandom & $urandom, $urandom & $urandom,
                       $urandom & $urandom, $urandom & $urandom};
                re  = {$urandom, $urandom, $urandom, $urandom};
                fe  = {$urandom, $urandom, $urandom, $urandom};
            end
            pin = pin ^ {$urandom & $urandom & $urandom & $urandom,
                         $urandom & $urandom & $urandom & $urandom,
                         $urandom & $urandom & $urandom & $urandom,
                         $urandom & $urandom & $urandom & $urandom};
            halted   = 1'($urandom);
            clr_we   = ($urandom % 4) == 0;
            clr_bank = 2'($urandom);
            clr_mask = $urandom;
            step(1);
        end
        clr_we = 1'b0;
        step(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule